// File: doc/BRIEF.md
# Dual-Compare Timer with Output Control

An 8-bit up-counter that advances by one on each clock cycle in which its count-enable input is high. It sits next to two compare registers, A and B. When the counter steps onto the value held in a compare register, that compare register's match flag is set. The same match can also act on a single timer output pin. A third flag records the counter wrapping past its top value.

Software reaches the counter, both compare values and a control/status register through a small register port. The port has a 2-bit address, read and write strobes and a combinational read-data path. The control/status register holds the three flags and a 4-bit output-select field. A flag can only be cleared deliberately. Software must first read the flag while it is set, and only then does a 0 written to that bit take effect.

The output-select field holds one 2-bit action for each comparator. When both comparators match on the same edge, the two actions are merged by a fixed priority. Clearing the whole field turns the pin off.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the counter reads 0x00, both compare registers read 0xFF, the control/status register reads 0x10, and both `tmr_out` and `tmr_oe` are 0.
- R2: Each clock edge with `cnt_en` high adds one to the counter. A write to address 0 loads the counter, and that load takes priority over counting in the same cycle.
- R3: The overflow flag (status bit 5) is set on the edge where the counter advances from 0xFF to 0x00.
- R4: The A match flag (bit 6) is set on the edge where the counter advances onto the value of compare register A (address 1). The B match flag (bit 7) does the same with compare register B (address 2). Loading the counter with a compare value does not count as a match.
- R5: Writing 1 to a flag bit never sets that flag.
- R6: Writing 0 to a flag bit clears the flag only if the status register (address 3) was read while that flag was 1. Once a flag has been cleared, a later hardware set requires a fresh read before a 0 write clears it again.
- R7: When a hardware set and a permitted software clear of the same flag fall on the same edge, the flag ends up set.
- R8: Status bit 4 always reads 1 and ignores writes. Bits 3:0 read back the output-select value last written.
- R9: Output-select bits 1:0 choose the action of an A match and bits 3:2 choose the action of a B match. Each 2-bit field is coded 00 = no change, 01 = drive 0, 10 = drive 1, 11 = toggle. The action is applied on the match edge, and an action whose comparator does not match has no effect.
- R10: When A and B match on the same edge, toggle beats drive 1, and drive 1 beats drive 0.
- R11: While all four output-select bits are 0, `tmr_oe` is 0 and `tmr_out` is 0. The output level is held meanwhile and reappears once a nonzero select is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable, one increment per cycle |
| bus_addr | input | 2 | Register select: 0 counter, 1 compare A, 2 compare B, 3 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clearing on address 3) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| tmr_out | output | 1 | Timer output pin level |
| tmr_oe | output | 1 | Timer output enable (any select bit set) |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a match on comparator A and a match on comparator B. The bench provokes it by setting both compare registers to the same value and stepping the counter onto that value once. For each pair of select codes it judges the pin level against the priority order, starting from a known level of 0 or 1. The second pair is a hardware flag set and an armed software clear. The bench provokes it by writing 0 to the armed overflow bit in the same cycle that the counter wraps, and then confirms through a status read that the flag survived.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_ZERO   = 2'b01,
        ACT_ONE    = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        REG_COUNT = 2'd0,
        REG_CMPA  = 2'd1,
        REG_CMPB  = 2'd2,
        REG_CSR   = 2'd3
    } reg_e;

    localparam int NUM_FLAGS  = 3;   // 0: overflow, 1: match A, 2: match B
    localparam int FLAG_LSB   = 5;   // flag i lives at status bit FLAG_LSB+i
    localparam int RSVD_BIT   = 4;
    localparam int SEL_W      = 4;
    localparam int CSR_W      = 8;

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          ld_cnt,
    input  logic          ld_cmpa,
    input  logic          ld_cmpb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] cnt,
    output logic [DW-1:0] cmpa,
    output logic [DW-1:0] cmpb,
    output logic          hit_a,
    output logic          hit_b,
    output logic          wrap
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] cmpa;
        logic [DW-1:0] cmpb;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic          step;
    logic [DW-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        step    = cnt_en && !ld_cnt;
        cnt_inc = st_q.cnt + DW'(1);
        hit_a   = step && (cnt_inc == st_q.cmpa);
        hit_b   = step && (cnt_inc == st_q.cmpb);
        wrap    = step && (st_q.cnt == {DW{1'b1}});
        if (ld_cnt) begin
            st_d.cnt = wdata;
        end else if (step) begin
            st_d.cnt = cnt_inc;
        end
        if (ld_cmpa) st_d.cmpa = wdata;
        if (ld_cmpb) st_d.cmpb = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.cmpa <= '1;
            st_q.cmpb <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign cmpa = st_q.cmpa;
    assign cmpb = st_q.cmpb;

    // R2: counting adds exactly one when no load competes
    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !ld_cnt) |=> (st_q.cnt == $past(st_q.cnt) + DW'(1)));

    // R2: a load wins over counting
    assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt |=> (st_q.cnt == $past(wdata)));

    // R4: after an A hit the counter holds the compare value
    assert_hit_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && !ld_cmpa) |=> (st_q.cnt == st_q.cmpa));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic rd_seen,
    input  logic clr_req,
    output logic flag
);

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_seen && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (clr_req && st_q.armed) begin
            st_d.armed = 1'b0;
            st_d.flag  = 1'b0;
        end
        if (hw_set) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R5: only hardware raises a flag
    assert_set_by_hw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flag) |-> $past(hw_set));

    // R6: a flag falls only after an armed clear request
    assert_clear_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.flag) |-> $past(clr_req && st_q.armed));

    // R7: hardware set wins the same edge
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> st_q.flag);

endmodule

// File: rtl/tmr_outctl.sv
module tmr_outctl
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             match_a,
    input  logic             match_b,
    input  logic [SEL_W-1:0] sel,
    output logic             pin,
    output logic             pin_oe
);

    typedef struct packed {
        logic level;
    } out_st_t;

    out_st_t st_d, st_q;
    act_e    act_a, act_b;

    always_comb begin
        st_d  = st_q;
        act_a = match_a ? act_e'(sel[1:0]) : ACT_NONE;
        act_b = match_b ? act_e'(sel[3:2]) : ACT_NONE;
        if (act_a == ACT_TOGGLE || act_b == ACT_TOGGLE) begin
            st_d.level = !st_q.level;
        end else if (act_a == ACT_ONE || act_b == ACT_ONE) begin
            st_d.level = 1'b1;
        end else if (act_a == ACT_ZERO || act_b == ACT_ZERO) begin
            st_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_oe = |sel;
    assign pin    = st_q.level && pin_oe;

    // R9: without a match the level holds
    assert_hold_no_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!match_a && !match_b) |=> $stable(st_q.level));

    // R10: a toggle in either field flips the level when both match
    assert_toggle_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a && match_b && (sel[1:0] == 2'b11 || sel[3:2] == 2'b11))
        |=> (st_q.level != $past(st_q.level)));

    // R10: drive 1 beats drive 0 when no toggle is selected
    assert_one_over_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (match_a && match_b && sel[1:0] != 2'b11 && sel[3:2] != 2'b11
         && (sel[1:0] == 2'b10 || sel[3:2] == 2'b10)) |=> st_q.level);

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          tmr_out,
    output logic          tmr_oe
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          wr_cnt, wr_cmpa, wr_cmpb, wr_csr, rd_csr;
    logic [DW-1:0] cnt, cmpa, cmpb;
    logic          hit_a, hit_b, wrap;
    logic [NUM_FLAGS-1:0] flag_set, flag_clr, flags;
    logic [CSR_W-1:0]     csr_view;

    always_comb begin
        wr_cnt  = bus_wr && (reg_e'(bus_addr) == REG_COUNT);
        wr_cmpa = bus_wr && (reg_e'(bus_addr) == REG_CMPA);
        wr_cmpb = bus_wr && (reg_e'(bus_addr) == REG_CMPB);
        wr_csr  = bus_wr && (reg_e'(bus_addr) == REG_CSR);
        rd_csr  = bus_rd && (reg_e'(bus_addr) == REG_CSR);
        st_d    = st_q;
        if (wr_csr) begin
            st_d.sel = bus_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    tmr_counter #(.DW(DW)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .ld_cnt  (wr_cnt),
        .ld_cmpa (wr_cmpa),
        .ld_cmpb (wr_cmpb),
        .wdata   (bus_wdata),
        .cnt     (cnt),
        .cmpa    (cmpa),
        .cmpb    (cmpb),
        .hit_a   (hit_a),
        .hit_b   (hit_b),
        .wrap    (wrap)
    );

    assign flag_set = {hit_b, hit_a, wrap};

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        assign flag_clr[i] = wr_csr && !bus_wdata[FLAG_LSB+i];
        tmr_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .hw_set  (flag_set[i]),
            .rd_seen (rd_csr),
            .clr_req (flag_clr[i]),
            .flag    (flags[i])
        );
    end

    tmr_outctl u_outctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .match_a (hit_a),
        .match_b (hit_b),
        .sel     (st_q.sel),
        .pin     (tmr_out),
        .pin_oe  (tmr_oe)
    );

    always_comb begin
        csr_view = {flags, 1'b1, st_q.sel};
        case (reg_e'(bus_addr))
            REG_COUNT: bus_rdata = cnt;
            REG_CMPA:  bus_rdata = cmpa;
            REG_CMPB:  bus_rdata = cmpb;
            default:   bus_rdata = DW'(csr_view);
        endcase
    end

    // R3: overflow flag rises only after the counter stood at its top value
    assert_ovf_from_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> ($past(cnt) == {DW{1'b1}}));

    // R11: a disabled pin stays low
    assert_pin_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_oe |-> !tmr_out);

    // R8: the select field follows a status write
    assert_sel_written_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_csr |=> (st_q.sel == $past(bus_wdata[SEL_W-1:0])));

endmodule

// File: tb/tb_dual_cmp_timer.sv
module tb_dual_cmp_timer;

    localparam int CLK_P = 10;
    localparam int NVEC  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_out, tmr_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    dual_cmp_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tmr_out   (tmr_out),
        .tmr_oe    (tmr_oe)
    );

    // {select[3:0], which(0 both,1 A only,2 B only), start level, expected level}
    localparam logic [7:0] VEC [NVEC] = '{
        {4'b0011, 2'd1, 1'b0, 1'b1},
        {4'b0001, 2'd1, 1'b1, 1'b0},
        {4'b0010, 2'd1, 1'b0, 1'b1},
        {4'b1100, 2'd2, 1'b1, 1'b0},
        {4'b0100, 2'd2, 1'b1, 1'b0},
        {4'b1000, 2'd2, 1'b0, 1'b1},
        {4'b0111, 2'd0, 1'b0, 1'b1},
        {4'b1101, 2'd0, 1'b1, 1'b0},
        {4'b1001, 2'd0, 1'b0, 1'b1},
        {4'b0110, 2'd0, 1'b0, 1'b1},
        {4'b0101, 2'd0, 1'b1, 1'b0},
        {4'b1111, 2'd0, 1'b0, 1'b1},
        {4'b1110, 2'd0, 1'b1, 1'b0},
        {4'b1011, 2'd0, 1'b1, 1'b0},
        {4'b0011, 2'd2, 1'b1, 1'b1},
        {4'b1000, 2'd1, 1'b0, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        cnt_en = 1'b1;
        @(negedge clk);
        cnt_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        do_reset();

        // R1 reset state
        #1;
        check(tmr_out == 1'b0, "R1 out", int'(tmr_out), 0);
        check(tmr_oe == 1'b0, "R1 oe", int'(tmr_oe), 0);
        rd(2'd0, d); check(d == 8'h00, "R1 count", d, 8'h00);
        rd(2'd1, d); check(d == 8'hFF, "R1 cmpA", d, 8'hFF);
        rd(2'd2, d); check(d == 8'hFF, "R1 cmpB", d, 8'hFF);
        rd(2'd3, d); check(d == 8'h10, "R1 csr", d, 8'h10);

        // R9 R10 vector table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            if (VEC[v][1]) begin
                wr(2'd1, 8'h10); wr(2'd2, 8'h90);
                wr(2'd3, 8'hE2); wr(2'd0, 8'h0F);
                step();
            end
            wr(2'd1, (VEC[v][3:2] == 2'd2) ? 8'h80 : 8'h40);
            wr(2'd2, (VEC[v][3:2] == 2'd1) ? 8'h80 : 8'h40);
            wr(2'd3, {4'hE, VEC[v][7:4]});
            wr(2'd0, 8'h3F);
            step();
            #1;
            check(tmr_out == VEC[v][0], $sformatf("R9/R10 vec%0d", v),
                  int'(tmr_out), int'(VEC[v][0]));
        end

        // R2 counting and load priority
        do_reset();
        wr(2'd0, 8'h20);
        repeat (3) step();
        rd(2'd0, d); check(d == 8'h23, "R2 count", d, 8'h23);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h50; bus_wr = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt_en = 1'b0;
        rd(2'd0, d); check(d == 8'h50, "R2 load wins", d, 8'h50);

        // R3 overflow
        do_reset();
        wr(2'd0, 8'hFF);
        step();
        rd(2'd0, d); check(d == 8'h00, "R3 wrap", d, 8'h00);
        rd(2'd3, d); check(d == 8'h30, "R3 ovf flag", d, 8'h30);

        // R4 match flags
        do_reset();
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h05);
        rd(2'd3, d); check(d[6] == 1'b0, "R4 load no match", d, 8'h10);
        wr(2'd0, 8'h04);
        step();
        rd(2'd3, d); check(d == 8'h50, "R4 A flag", d, 8'h50);
        wr(2'd2, 8'h06);
        step();
        rd(2'd3, d); check(d == 8'hD0, "R4 B flag", d, 8'hD0);

        // R5 writing ones does not set flags
        do_reset();
        wr(2'd3, 8'hE0);
        rd(2'd3, d); check(d == 8'h10, "R5 no sw set", d, 8'h10);

        // R6 read-then-write-zero
        do_reset();
        wr(2'd0, 8'hFF);
        step();
        wr(2'd3, 8'hC0);
        rd(2'd3, d); check(d[5] == 1'b1, "R6 unread clear ignored", d, 8'h30);
        wr(2'd3, 8'hC0);
        rd(2'd3, d); check(d[5] == 1'b0, "R6 armed clear", d, 8'h10);
        wr(2'd0, 8'hFF);
        step();
        wr(2'd3, 8'hC0);
        @(negedge clk); #1;
        bus_addr = 2'd3;
        #1 check(bus_rdata[5] == 1'b1, "R6 rearm needed", bus_rdata, 8'h30);

        // R7 set wins over armed clear (status read below arms the flag)
        rd(2'd3, d);
        wr(2'd0, 8'hFF);
        @(negedge clk);
        bus_addr = 2'd3; bus_wdata = 8'hC0; bus_wr = 1'b1; cnt_en = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; cnt_en = 1'b0;
        #1 bus_addr = 2'd3;
        #1 check(bus_rdata[5] == 1'b1, "R7 set wins", bus_rdata, 8'h30);

        // R8 reserved bit and select readback
        do_reset();
        wr(2'd3, 8'h05);
        rd(2'd3, d); check(d == 8'h15, "R8 readback", d, 8'h15);

        // R11 disabled output
        do_reset();
        wr(2'd1, 8'h10); wr(2'd3, 8'hE2); wr(2'd0, 8'h0F);
        step();
        #1 check(tmr_out && tmr_oe, "R11 enabled high", {tmr_out, tmr_oe}, 3);
        wr(2'd3, 8'hE0);
        #1 check(!tmr_out && !tmr_oe, "R11 disabled", {tmr_out, tmr_oe}, 0);
        wr(2'd3, 8'hE2);
        #1 check(tmr_out && tmr_oe, "R11 level held", {tmr_out, tmr_oe}, 3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule